// File: doc/BRIEF.md
# Packet-Framed RAM Image Loader

This block takes in a stream of bytes, cuts it into fixed 64-byte packets and copies a program image into working RAM. It keeps scanning packets until one opens with the agreed header word. That packet is the parameter packet. It says how many data packets follow, where the first one is stored and where execution starts. Every data packet after it becomes sixteen 32-bit writes on a single-outstanding memory write port. Each packet lands at the next word address after the packet before it. When the final packet has been written, the block raises a one-cycle jump strobe that carries the start address. After that it stops accepting bytes until the next reset.

The working RAM can be reached through two address windows, one based at 0x30000000 and one based at 0x00000000. The lowest 4 KB of that RAM holds the boot code that is running, and it has to survive the load. Any image word whose address falls in that region, through either window, is dropped. The address still moves on past the dropped word, and a sticky error output records that it happened. The upstream transport feeds bytes through a valid/ready handshake. The memory side answers each write with an acknowledge pulse.

Top module: `pkt_boot_loader`

## Requirements
- R1: Bytes are grouped into 64-byte packets counted from reset. Only words 0 to 3 of the parameter packet affect the outcome. The remaining twelve words are ignored, even if they hold the header value.
- R2: A packet is a parameter packet only if its word 0 equals 0xF0000000. Any other packet is discarded whole, and the next packet is examined as a candidate. The header value appearing at any other word position of a discarded packet has no effect.
- R3: Each 32-bit word is little-endian. The first byte received for a word becomes bits 7:0 and the fourth becomes bits 31:24.
- R4: Word 1 gives N, the number of data packets. Word 2 gives the destination D. Data word k (counting from 0 across all N packets) is written with address D + 4k.
- R5: After the last data word has been acknowledged (or dropped), `jump_valid` is high for exactly one cycle with `jump_addr` equal to word 3. `jump_addr` then keeps that value.
- R6: When N = 0, the jump follows the end of the parameter packet and no memory write is issued.
- R7: A word whose address lies in 0x30000000–0x30000FFF or 0x00000000–0x00000FFF is never written. Its address slot is still used up, and `prot_err` goes high and stays high until reset.
- R8: `mem_wr_en` stays high with a stable address and data until `mem_wr_ack` is seen. `in_ready` is low while a write is pending.
- R9: After reset `in_ready` is 1 and `mem_wr_en`, `jump_valid` and `prot_err` are 0. After the jump, `in_ready` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered by the transport |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Loader takes the byte on this edge if `in_valid` is high |
| mem_wr_en | output | 1 | Write request, held until acknowledged |
| mem_wr_addr | output | 32 | Byte address of the word being written |
| mem_wr_data | output | 32 | Word being written |
| mem_wr_ack | input | 1 | Memory accepted the pending write |
| jump_valid | output | 1 | One-cycle strobe: image loaded, start execution |
| jump_addr | output | 32 | Start address carried by the strobe |
| prot_err | output | 1 | Sticky: a write into the boot region was dropped |

## Verification
The bench sweeps the number of leading junk packets, the data packet count from zero up, and destinations on both address windows, including ones that begin inside the protected 4 KB and run out of it. Some junk packets differ from the header by a single bit. Others carry the header one word late. A loader that compared only part of the word, or that re-aligned its hunt to the word level, would mistake one of these for a parameter packet and write to the wrong place. A guard that checked only one window, or that failed to advance the address past a dropped word, shows up as writes that are missing or shifted. The bench also stretches acknowledges over several cycles. A loader that leaked bytes in during a pending write, or jumped before the last acknowledge, would corrupt data or report the jump too early.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SKIP,
    ST_PARAM,
    ST_DATA,
    ST_WRITE,
    ST_JUMP,
    ST_DONE
  } ldr_state_e;

  // true when addr falls within glen bytes above either window base
  function automatic logic addr_in_guard(input logic [31:0] addr,
                                         input logic [31:0] base_a,
                                         input logic [31:0] base_b,
                                         input logic [31:0] glen);
    logic [31:0] off_a;
    logic [31:0] off_b;
    off_a = addr - base_a;
    off_b = addr - base_b;
    return (off_a < glen) || (off_b < glen);
  endfunction

  // address of the word that follows addr
  function automatic logic [31:0] next_word_addr(input logic [31:0] addr);
    return addr + 32'd4;
  endfunction

  // place byte b into lane of a partially built little-endian word
  function automatic logic [23:0] lane_insert(input logic [23:0] acc,
                                              input logic [1:0]  lane,
                                              input logic [7:0]  b);
    logic [23:0] r;
    r = acc;
    case (lane)
      2'd0:    r[7:0]   = b;
      2'd1:    r[15:8]  = b;
      default: r[23:16] = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/boot_word_packer.sv
module boot_word_packer #(
  parameter int PKT_BYTES = 64,
  localparam int WORDS    = PKT_BYTES / 4,
  localparam int BCW      = $clog2(PKT_BYTES),
  localparam int WIW      = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_fire,
  input  logic [7:0]     byte_in,
  output logic           word_vld,
  output logic [31:0]    word_q,
  output logic [WIW-1:0] word_idx,
  output logic           word_last
);
  import boot_ldr_pkg::*;

  localparam logic [BCW-1:0] LAST_BYTE = BCW'(PKT_BYTES - 1);

  logic [BCW-1:0] byte_cnt;
  logic [23:0]    acc;
  logic [1:0]     lane;

  assign lane = byte_cnt[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt  <= '0;
      acc       <= '0;
      word_vld  <= 1'b0;
      word_q    <= '0;
      word_idx  <= '0;
      word_last <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (byte_fire) begin
        if (lane == 2'd3) begin
          word_q    <= {byte_in, acc};
          word_vld  <= 1'b1;
          word_idx  <= byte_cnt[BCW-1:2];
          word_last <= (byte_cnt == LAST_BYTE);
        end else begin
          acc <= lane_insert(acc, lane, byte_in);
        end
        byte_cnt <= (byte_cnt == LAST_BYTE) ? '0 : byte_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/boot_region_guard.sv
module boot_region_guard #(
  parameter logic [31:0] RAM_BASE    = 32'h3000_0000,
  parameter logic [31:0] ALIAS_BASE  = 32'h0000_0000,
  parameter logic [31:0] GUARD_BYTES = 32'h0000_1000
) (
  input  logic [31:0] addr,
  output logic        hit
);
  import boot_ldr_pkg::*;

  always_comb hit = addr_in_guard(addr, RAM_BASE, ALIAS_BASE, GUARD_BYTES);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl #(
  parameter int          WIW   = 4,
  parameter logic [31:0] MAGIC = 32'hF000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           word_vld,
  input  logic [31:0]    word_q,
  input  logic [WIW-1:0] word_idx,
  input  logic           word_last,
  input  logic           guard_hit,
  input  logic           mem_wr_ack,
  output logic [31:0]    cur_addr,
  output logic [31:0]    wr_data,
  output logic           wr_en,
  output logic           jump_pulse,
  output logic [31:0]    start_addr,
  output logic           err_flag,
  output logic           take_bytes
);
  import boot_ldr_pkg::*;

  ldr_state_e  state;
  logic [31:0] pkts_left;
  logic        pkt_end_q;

  assign wr_en      = (state == ST_WRITE);
  assign jump_pulse = (state == ST_JUMP);
  assign take_bytes = (state == ST_HUNT) || (state == ST_SKIP) ||
                      (state == ST_PARAM) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      pkts_left  <= '0;
      pkt_end_q  <= 1'b0;
      cur_addr   <= '0;
      wr_data    <= '0;
      start_addr <= '0;
      err_flag   <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: if (word_vld) begin
          state <= (word_q == MAGIC) ? ST_PARAM : ST_SKIP;
        end
        ST_SKIP: if (word_vld && word_last) begin
          state <= ST_HUNT;
        end
        ST_PARAM: if (word_vld) begin
          if (word_idx == WIW'(1)) pkts_left  <= word_q;
          if (word_idx == WIW'(2)) cur_addr   <= word_q;
          if (word_idx == WIW'(3)) start_addr <= word_q;
          if (word_last) state <= (pkts_left == '0) ? ST_JUMP : ST_DATA;
        end
        ST_DATA: if (word_vld) begin
          wr_data   <= word_q;
          pkt_end_q <= word_last;
          if (guard_hit) begin
            err_flag <= 1'b1;
            cur_addr <= next_word_addr(cur_addr);
            if (word_last) begin
              pkts_left <= pkts_left - 32'd1;
              if (pkts_left == 32'd1) state <= ST_JUMP;
            end
          end else begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: if (mem_wr_ack) begin
          cur_addr <= next_word_addr(cur_addr);
          if (pkt_end_q) begin
            pkts_left <= pkts_left - 32'd1;
            state     <= (pkts_left == 32'd1) ? ST_JUMP : ST_DATA;
          end else begin
            state <= ST_DATA;
          end
        end
        ST_JUMP: state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_boot_loader.sv
module pkt_boot_loader #(
  parameter int          PKT_BYTES   = 64,
  parameter logic [31:0] MAGIC       = 32'hF000_0000,
  parameter logic [31:0] RAM_BASE    = 32'h3000_0000,
  parameter logic [31:0] ALIAS_BASE  = 32'h0000_0000,
  parameter logic [31:0] GUARD_BYTES = 32'h0000_1000,
  localparam int WIW = $clog2(PKT_BYTES / 4)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        mem_wr_en,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ack,
  output logic        jump_valid,
  output logic [31:0] jump_addr,
  output logic        prot_err
);

  // named internal events
  logic           byte_fire;
  logic           word_vld;
  logic [31:0]    word_q;
  logic [WIW-1:0] word_idx;
  logic           word_last;
  logic           guard_hit;
  logic           take_bytes;
  logic [31:0]    cur_addr;

  assign in_ready  = take_bytes && !word_vld;
  assign byte_fire = in_valid && in_ready;

  boot_word_packer #(.PKT_BYTES(PKT_BYTES)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_fire (byte_fire),
    .byte_in   (in_data),
    .word_vld  (word_vld),
    .word_q    (word_q),
    .word_idx  (word_idx),
    .word_last (word_last)
  );

  boot_region_guard #(
    .RAM_BASE    (RAM_BASE),
    .ALIAS_BASE  (ALIAS_BASE),
    .GUARD_BYTES (GUARD_BYTES)
  ) u_guard (
    .addr (cur_addr),
    .hit  (guard_hit)
  );

  boot_seq_ctrl #(.WIW(WIW), .MAGIC(MAGIC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .word_q     (word_q),
    .word_idx   (word_idx),
    .word_last  (word_last),
    .guard_hit  (guard_hit),
    .mem_wr_ack (mem_wr_ack),
    .cur_addr   (cur_addr),
    .wr_data    (mem_wr_data),
    .wr_en      (mem_wr_en),
    .jump_pulse (jump_valid),
    .start_addr (jump_addr),
    .err_flag   (prot_err),
    .take_bytes (take_bytes)
  );

  assign mem_wr_addr = cur_addr;

endmodule

// File: rtl/pkt_boot_loader_chk.sv
module pkt_boot_loader_chk #(
  parameter logic [31:0] RAM_BASE    = 32'h3000_0000,
  parameter logic [31:0] ALIAS_BASE  = 32'h0000_0000,
  parameter logic [31:0] GUARD_BYTES = 32'h0000_1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        mem_wr_en,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data,
  input logic        mem_wr_ack,
  input logic        jump_valid,
  input logic [31:0] jump_addr,
  input logic        prot_err,
  input logic        word_vld
);

  logic wr_outside_guard;
  assign wr_outside_guard = ((mem_wr_addr - RAM_BASE) >= GUARD_BYTES) &&
                            ((mem_wr_addr - ALIAS_BASE) >= GUARD_BYTES);

  AST_NO_READY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !in_ready); // R8
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_wr_ack) |=> (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R8
  AST_WORD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> !in_ready); // R8
  AST_NO_GUARDED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> wr_outside_guard); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err); // R7
  AST_JUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !jump_valid); // R5
  AST_JUMP_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> $stable(jump_addr)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> (!in_ready && !mem_wr_en)); // R9

endmodule

bind pkt_boot_loader pkt_boot_loader_chk #(
  .RAM_BASE    (RAM_BASE),
  .ALIAS_BASE  (ALIAS_BASE),
  .GUARD_BYTES (GUARD_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_ack  (mem_wr_ack),
  .jump_valid  (jump_valid),
  .jump_addr   (jump_addr),
  .prot_err    (prot_err),
  .word_vld    (word_vld)
);

// File: tb/pkt_boot_loader_bench.sv
module pkt_boot_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        mem_wr_ack = 1'b0;
  logic        jump_valid;
  logic [31:0] jump_addr;
  logic        prot_err;

  always #10 clk = ~clk;

  pkt_boot_loader u_pkt_boot_loader (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .in_ready (in_ready), .mem_wr_en (mem_wr_en), .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data), .mem_wr_ack (mem_wr_ack),
    .jump_valid (jump_valid), .jump_addr (jump_addr), .prot_err (prot_err)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] exp_addr [0:63];
  logic [31:0] exp_data [0:63];
  int n_exp;
  int got_writes;
  int wait_cnt;
  int jumps;
  int writes_at_jump;
  logic [31:0] seen_jaddr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seq, input int i);
    return 8'((seq * 29 + i * 7 + (i >> 3) + 3) & 255);
  endfunction

  function automatic bit guarded(input logic [31:0] a);
    return (a < 32'h0000_1000) ||
           (a >= 32'h3000_0000 && a <= 32'h3000_0FFF);
  endfunction

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // memory responder and write checker, sampling away from the active edge
  always @(negedge clk) begin
    if (mem_wr_ack) begin
      mem_wr_ack = 1'b0;
    end else if (mem_wr_en) begin
      check(!in_ready, "R8", "in_ready during write", 32'(in_ready), 32'd0);
      if (wait_cnt >= (got_writes % 3)) begin
        if (got_writes < n_exp) begin
          check(mem_wr_addr == exp_addr[got_writes], "R4", "write address",
                mem_wr_addr, exp_addr[got_writes]);
          check(mem_wr_data == exp_data[got_writes], "R3", "write data",
                mem_wr_data, exp_data[got_writes]);
        end else begin
          check(1'b0, "R7", "unexpected write", mem_wr_addr, 32'hFFFF_FFFF);
        end
        got_writes++;
        wait_cnt = 0;
        mem_wr_ack = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
    if (jump_valid) begin
      jumps++;
      seen_jaddr = jump_addr;
      writes_at_jump = got_writes;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    mem_wr_ack = 1'b0;
    got_writes = 0;
    wait_cnt = 0;
    jumps = 0;
    writes_at_jump = -1;
    seen_jaddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_case(input int junk, input int npk, input logic [31:0] dest,
                          input int seq);
    logic [31:0] start;
    bit exp_err;
    start = dest + 32'(seq * 16);
    do_reset();
    n_exp = 0;
    exp_err = 1'b0;
    for (int k = 0; k < npk * 16; k++) begin
      logic [31:0] a;
      a = dest + 32'(4 * k);
      if (guarded(a)) exp_err = 1'b1;
      else begin
        exp_addr[n_exp] = a;
        exp_data[n_exp] = {pay(seq, 4*k+3), pay(seq, 4*k+2), pay(seq, 4*k+1), pay(seq, 4*k)};
        n_exp++;
      end
    end
    // R2: near-miss headers and late headers must be skipped whole
    for (int j = 0; j < junk; j++) begin
      send_word((j == 0) ? 32'hF000_0001 : 32'h7000_0000);
      send_word(32'hF000_0000);
      send_word(32'h0000_0001);
      for (int w = 3; w < 16; w++) send_word(32'hF000_0000 ^ 32'(w * j));
    end
    send_word(32'hF000_0000);
    send_word(32'(npk));
    send_word(dest);
    send_word(start);
    // R1: trailing words of the parameter packet carry noise
    for (int w = 4; w < 16; w++) send_word((w == 5) ? 32'hF000_0000 : 32'hDEAD_0000 + 32'(w));
    for (int i = 0; i < npk * 64; i++) send_byte(pay(seq, i));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(got_writes == n_exp, (npk == 0) ? "R6" : "R4", "write count",
          32'(got_writes), 32'(n_exp));
    check(jumps == 1, "R5", "jump pulses", 32'(jumps), 32'd1);
    check(seen_jaddr == start, "R1", "jump address", seen_jaddr, start);
    check(writes_at_jump == n_exp, "R5", "writes before jump",
          32'(writes_at_jump), 32'(n_exp));
    check(jump_addr == start, "R5", "jump address held", jump_addr, start);
    check(prot_err == exp_err, "R7", "protection flag", 32'(prot_err), 32'(exp_err));
    check(!in_ready, "R9", "ready after jump", 32'(in_ready), 32'd0);
  endtask

  initial begin
    logic [31:0] dests [4];
    int seq;
    dests[0] = 32'h3000_1000;
    dests[1] = 32'h0000_2000;
    dests[2] = 32'h3000_0FC0;
    dests[3] = 32'h0000_0F80;
    do_reset();
    check(in_ready == 1'b1, "R9", "reset in_ready", 32'(in_ready), 32'd1);
    check(mem_wr_en == 1'b0, "R9", "reset mem_wr_en", 32'(mem_wr_en), 32'd0);
    check(jump_valid == 1'b0, "R9", "reset jump_valid", 32'(jump_valid), 32'd0);
    check(prot_err == 1'b0, "R9", "reset prot_err", 32'(prot_err), 32'd0);
    seq = 1;
    for (int junk = 0; junk < 3; junk++)
      for (int npk = 0; npk < 4; npk++)
        for (int d = 0; d < 4; d++) begin
          run_case(junk, npk, dests[d], seq);
          seq++;
        end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule